// File: doc/BRIEF.md
# Split-Transaction Request Queue Scheduler

This block sits on the host side of a split-transaction graphics port. The card posts address-phase requests, each made of a 4-bit command, an 8-byte-aligned address and a 3-bit length code. The block keeps them in an age-ordered store and later schedules the matching data phases, one grant per cycle. Every grant carries a 3-bit status code that marks it as a read return or a write transfer.

Ordering is weak. Reads leave in the order they were accepted, and so do writes. A write may overtake an older read that is still waiting for memory data. A fence stops anything younger from leaving until everything older has gone. A flush takes a slot like a read and is answered with a dummy 8-byte read return. Occupancy is capped by a depth value supplied at initialization. The memory behind the queue signals through `rd_ready` that read data can be returned in the current cycle.

Top module: `splitq_sched`

## Requirements
- R1: A request with a known command and `req_valid` high is accepted when occupancy is below the limit. Its command, address and length are stored together as one entry, in arrival order.
- R2: The command codes are 4'b0000 read, 4'b0100 write, 4'b1010 flush and 4'b1100 fence. Any other code is ignored: nothing is stored and the overflow flag is not set.
- R3: The limit is the smaller of `cfg_depth` and DEPTH. Occupancy never exceeds the limit, and `q_full` is high exactly when occupancy is at or above it.
- R4: A known request that arrives while `q_full` is high is dropped and sets `q_overflow`. The flag then stays high until reset.
- R5: Grant status 3'b000 is a read return and 3'b010 is a write transfer; the priority bit (bit 0) is always 0. Status 3'b111 means no grant. A grant is registered and appears on the clock edge after the decision, so at the earliest on the second edge after acceptance. The grant address has bits [2:0] at zero, and the length code L is passed through unchanged, meaning 8×(L+1) bytes.
- R6: Reads and flushes are granted in acceptance order. A read is granted only in a cycle where `rd_ready` is high.
- R7: Writes are granted in acceptance order. The oldest eligible entry goes first, so a write overtakes an older read only while that read is waiting for `rd_ready`.
- R8: No entry younger than a fence is granted before every entry older than the fence has been granted. The fence leaves the queue without a grant in the cycle it becomes the oldest entry.
- R9: A flush is granted as a read return with `gnt_dummy` high, address 0 and length code 0. It does not wait for `rd_ready`, but it still stays behind older reads.
- R10: When one request is accepted and one entry leaves in the same cycle, occupancy is unchanged. Acceptance is decided on the occupancy at the start of the cycle, so a request that arrives while full is dropped even if an entry leaves in that same cycle.
- R11: After reset the queue is empty, `q_overflow` is low, `gnt_valid` is low and `gnt_st` is 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_depth | input | $clog2(DEPTH+1) | Maximum outstanding requests, stable after initialization |
| req_valid | input | 1 | Request present this cycle |
| req_cmd | input | 4 | Request command code |
| req_addr | input | 32 | Request byte address (low 3 bits ignored) |
| req_len | input | 3 | Length code L, 8×(L+1) bytes |
| rd_ready | input | 1 | Memory can return read data this cycle |
| q_full | output | 1 | Occupancy at or above the limit |
| q_overflow | output | 1 | Sticky: a request was dropped while full |
| gnt_valid | output | 1 | A data-phase grant is issued |
| gnt_st | output | 3 | Grant status code |
| gnt_addr | output | 32 | Grant address, 8-byte aligned |
| gnt_len | output | 3 | Grant length code |
| gnt_dummy | output | 1 | Grant is the dummy completion of a flush |

## Verification
Two events can fall in the same cycle: a new request being accepted and a stored entry leaving the queue. The bench provokes this by presenting a request on the same edge where `rd_ready` is first raised for a waiting read. It does this once with the queue below the limit and once with the queue full. In the first case, `q_full` must stay low after the exchange and rise only with the next request. In the second case, the incoming request must be dropped, `q_overflow` must rise, and only the older reads must be granted.

// File: rtl/splitq_pkg.sv
package splitq_pkg;

    localparam int ADDR_W = 32;
    localparam int OFS_W  = 3;
    localparam int LEN_W  = 3;

    typedef enum logic [3:0] {
        CMD_READ  = 4'b0000,
        CMD_WRITE = 4'b0100,
        CMD_FLUSH = 4'b1010,
        CMD_FENCE = 4'b1100
    } cmd_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_FENCE,
        SEL_READ,
        SEL_WRITE
    } sel_e;

    localparam logic [2:0] ST_READ  = 3'b000;
    localparam logic [2:0] ST_WRITE = 3'b010;
    localparam logic [2:0] ST_IDLE  = 3'b111;

    typedef struct packed {
        cmd_e                     cmd;
        logic [ADDR_W-OFS_W-1:0]  line;
        logic [LEN_W-1:0]         len;
    } entry_t;

    function automatic logic cmd_known(logic [3:0] c);
        return (c == 4'b0000) || (c == 4'b0100) || (c == 4'b1010) || (c == 4'b1100);
    endfunction

    function automatic logic read_class(cmd_e c);
        return (c == CMD_READ) || (c == CMD_FLUSH);
    endfunction

endpackage

// File: rtl/splitq_store.sv
module splitq_store
    import splitq_pkg::*;
#(
    parameter int  DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  entry_t            push_ent,
    input  logic              pop,
    input  logic [IDX_W-1:0]  pop_idx,
    output entry_t            slots [DEPTH],
    output logic [CNT_W-1:0]  occ
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    entry_t           nxt [DEPTH];
    logic [CNT_W-1:0] n;

    // Compacting store: index 0 is always the oldest entry.
    always_comb begin
        nxt = slots;
        n   = occ;
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (i >= int'(pop_idx)) nxt[i] = slots[i+1];
            end
            n = occ - ONE;
        end
        if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i == int'(n)) nxt[i] = push_ent;
            end
            n = n + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= '0;
        end else begin
            occ   <= n;
            slots <= nxt;
        end
    end

    assert_swap_keeps_occ_R10: assert property (@(posedge clk) disable iff (rst)
        (push && pop) |=> (occ == $past(occ)))
        else $error("occupancy changed on simultaneous accept and issue");

    assert_no_pop_empty_R6: assert property (@(posedge clk) disable iff (rst)
        pop |-> (occ != '0))
        else $error("entry removed from empty store");

endmodule

// File: rtl/splitq_pick.sv
module splitq_pick
    import splitq_pkg::*;
#(
    parameter int  DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmds [DEPTH],
    input  logic [CNT_W-1:0]  occ,
    input  logic              rd_ready,
    output sel_e              sel,
    output logic [IDX_W-1:0]  sel_idx
);

    logic             blocked, rd_hit, wr_hit, rd_go;
    logic [IDX_W-1:0] rd_at, wr_at;

    always_comb begin
        blocked = 1'b0;
        rd_hit  = 1'b0;
        wr_hit  = 1'b0;
        rd_at   = '0;
        wr_at   = '0;
        // Only entries older than the first fence are candidates.
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(occ) && !blocked) begin
                if (cmds[i] == CMD_FENCE) begin
                    blocked = 1'b1;
                end else if (read_class(cmds[i])) begin
                    if (!rd_hit) begin
                        rd_hit = 1'b1;
                        rd_at  = IDX_W'(i);
                    end
                end else if (!wr_hit) begin
                    wr_hit = 1'b1;
                    wr_at  = IDX_W'(i);
                end
            end
        end
        rd_go   = rd_hit && ((cmds[rd_at] == CMD_FLUSH) || rd_ready);
        sel     = SEL_NONE;
        sel_idx = '0;
        if (occ != '0 && cmds[0] == CMD_FENCE) begin
            sel = SEL_FENCE;
        end else if (rd_go && (!wr_hit || rd_at < wr_at)) begin
            sel     = SEL_READ;
            sel_idx = rd_at;
        end else if (wr_hit) begin
            sel     = SEL_WRITE;
            sel_idx = wr_at;
        end
    end

    assert_read_needs_data_R6: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_READ && cmds[sel_idx] == CMD_READ) |-> rd_ready)
        else $error("read issued without memory data");

endmodule

// File: rtl/splitq_sched.sv
module splitq_sched
    import splitq_pkg::*;
#(
    parameter int  DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cfg_depth,
    input  logic              req_valid,
    input  logic [3:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              rd_ready,
    output logic              q_full,
    output logic              q_overflow,
    output logic              gnt_valid,
    output logic [2:0]        gnt_st,
    output logic [ADDR_W-1:0] gnt_addr,
    output logic [LEN_W-1:0]  gnt_len,
    output logic              gnt_dummy
);

    entry_t           slots [DEPTH];
    cmd_e             cmds  [DEPTH];
    logic [CNT_W-1:0] occ, limit;
    logic             known, accept;
    entry_t           in_ent;
    sel_e             sel;
    logic [IDX_W-1:0] sel_idx;
    entry_t           head;

    assign limit  = (cfg_depth > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : cfg_depth;
    assign q_full = (occ >= limit);
    assign known  = cmd_known(req_cmd);
    assign accept = req_valid && known && !q_full;

    always_comb begin
        in_ent.cmd  = cmd_e'(req_cmd);
        in_ent.line = (ADDR_W-OFS_W)'(req_addr >> OFS_W);
        in_ent.len  = req_len;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmd
        assign cmds[g] = slots[g].cmd;
    end

    splitq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .push     (accept),
        .push_ent (in_ent),
        .pop      (sel != SEL_NONE),
        .pop_idx  (sel_idx),
        .slots    (slots),
        .occ      (occ)
    );

    splitq_pick #(.DEPTH(DEPTH)) u_pick (
        .clk      (clk),
        .rst      (rst),
        .cmds     (cmds),
        .occ      (occ),
        .rd_ready (rd_ready),
        .sel      (sel),
        .sel_idx  (sel_idx)
    );

    assign head = slots[sel_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            q_overflow <= 1'b0;
        end else if (req_valid && known && q_full) begin
            q_overflow <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_valid <= 1'b0;
            gnt_st    <= ST_IDLE;
            gnt_addr  <= '0;
            gnt_len   <= '0;
            gnt_dummy <= 1'b0;
        end else begin
            gnt_valid <= 1'b0;
            gnt_st    <= ST_IDLE;
            gnt_addr  <= '0;
            gnt_len   <= '0;
            gnt_dummy <= 1'b0;
            if (sel == SEL_READ || sel == SEL_WRITE) begin
                gnt_valid <= 1'b1;
                gnt_st    <= (sel == SEL_READ) ? ST_READ : ST_WRITE;
                if (head.cmd == CMD_FLUSH) begin
                    gnt_dummy <= 1'b1;
                end else begin
                    gnt_addr <= {head.line, {OFS_W{1'b0}}};
                    gnt_len  <= head.len;
                end
            end
        end
    end

    assert_occ_limit_R3: assert property (@(posedge clk) disable iff (rst)
        occ <= limit)
        else $error("occupancy above configured limit");

    assert_overflow_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        q_overflow |=> q_overflow)
        else $error("overflow flag cleared without reset");

    assert_status_code_R5: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> (gnt_st == ST_READ || gnt_st == ST_WRITE))
        else $error("grant with illegal status");

    assert_idle_code_R5: assert property (@(posedge clk) disable iff (rst)
        !gnt_valid |-> (gnt_st == ST_IDLE))
        else $error("idle status missing");

    assert_aligned_R5: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> (gnt_addr[OFS_W-1:0] == '0))
        else $error("grant address not aligned");

    assert_dummy_form_R9: assert property (@(posedge clk) disable iff (rst)
        gnt_dummy |-> (gnt_valid && gnt_st == ST_READ && gnt_len == '0 && gnt_addr == '0))
        else $error("malformed flush completion");

endmodule

// File: tb/splitq_sched_bench.sv
module splitq_sched_bench;

    localparam int DEPTH  = 8;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int RD_LAT = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CNT_W-1:0] cfg_depth = CNT_W'(DEPTH);
    logic             req_valid = 1'b0;
    logic [3:0]       req_cmd = 4'b0;
    logic [31:0]      req_addr = '0;
    logic [2:0]       req_len = '0;
    logic             rd_force = 1'b0;
    logic             rd_pulse = 1'b0;
    logic             mem_on = 1'b0;
    logic             rd_ready;
    logic             q_full, q_overflow, gnt_valid, gnt_dummy;
    logic [2:0]       gnt_st, gnt_len;
    logic [31:0]      gnt_addr;

    always #5 clk = ~clk;

    assign rd_ready = rd_force | rd_pulse;

    splitq_sched #(.DEPTH(DEPTH)) u_splitq_sched (
        .clk(clk), .rst(rst), .cfg_depth(cfg_depth),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len),
        .rd_ready(rd_ready), .q_full(q_full), .q_overflow(q_overflow),
        .gnt_valid(gnt_valid), .gnt_st(gnt_st), .gnt_addr(gnt_addr),
        .gnt_len(gnt_len), .gnt_dummy(gnt_dummy)
    );

    // Fixed-latency memory responder: read data ready every RD_LAT cycles.
    int lat_cnt = 0;
    always @(posedge clk) begin
        lat_cnt  <= (lat_cnt == RD_LAT - 1) ? 0 : lat_cnt + 1;
        rd_pulse <= mem_on && (lat_cnt == RD_LAT - 1);
    end

    typedef struct packed {
        logic [2:0]  st;
        logic [31:0] addr;
        logic [2:0]  len;
        logic        dummy;
    } gexp_t;

    gexp_t exp_q [$];
    string tag_q [$];
    int    n_chk  = 0;
    int    n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_gnt(input logic [2:0] st, input logic [31:0] addr,
                              input logic [2:0] len, input logic dummy, input string tag);
        exp_q.push_back('{st: st, addr: addr, len: len, dummy: dummy});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare every grant with the oldest expectation.
    always @(negedge clk) begin
        if (!rst && gnt_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected grant addr", 64'(gnt_addr), 64'hFFFF_FFFF);
            end else begin
                gexp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({gnt_st, gnt_addr, gnt_len, gnt_dummy} == e, t, "grant {st,addr,len,dummy}",
                      64'({gnt_st, gnt_addr, gnt_len, gnt_dummy}), 64'(e));
            end
        end
    end

    task automatic send(input logic [3:0] cmd, input logic [31:0] addr, input logic [2:0] len);
        @(negedge clk);
        req_valid = 1'b1;
        req_cmd   = cmd;
        req_addr  = addr;
        req_len   = len;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input int depth);
        @(negedge clk);
        rst = 1'b1;
        rd_force = 1'b0;
        mem_on = 1'b0;
        cfg_depth = CNT_W'(depth);
        idle(2);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        check(exp_q.size() == 0, "R6", "grants still missing", 64'(exp_q.size()), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(2);
        // R11: reset state
        check(gnt_valid == 1'b0, "R11", "gnt_valid", 64'(gnt_valid), 0);
        check(gnt_st == 3'b111, "R11", "gnt_st", 64'(gnt_st), 64'h7);
        check(q_overflow == 1'b0, "R11", "overflow", 64'(q_overflow), 0);
        rst = 1'b0;
        idle(1);
        check(q_full == 1'b0, "R11", "full after reset", 64'(q_full), 0);

        // R1 R5: reads in order, low address bits dropped, latency of one edge after acceptance
        rd_force = 1'b1;
        expect_gnt(3'b000, 32'h0000_1000, 3'd2, 1'b0, "R5");
        expect_gnt(3'b000, 32'h0000_2008, 3'd7, 1'b0, "R1");
        send(4'b0000, 32'h0000_1005, 3'd2);
        check(gnt_valid == 1'b0, "R5", "grant before decision edge", 64'(gnt_valid), 0);
        @(negedge clk);
        check(gnt_valid == 1'b1, "R5", "grant on second edge", 64'(gnt_valid), 1);
        send(4'b0000, 32'h0000_200F, 3'd7);
        idle(3);

        // R7: writes in order
        expect_gnt(3'b010, 32'h0000_3000, 3'd0, 1'b0, "R7");
        expect_gnt(3'b010, 32'h0000_3040, 3'd1, 1'b0, "R7");
        expect_gnt(3'b010, 32'h0000_3080, 3'd3, 1'b0, "R7");
        send(4'b0100, 32'h0000_3000, 3'd0);
        send(4'b0100, 32'h0000_3040, 3'd1);
        send(4'b0100, 32'h0000_3080, 3'd3);
        idle(4);

        // R2: unknown code not stored (depth 1 shows it through q_full)
        do_reset(1);
        send(4'b0010, 32'h0000_4000, 3'd1);
        check(q_full == 1'b0, "R2", "full after unknown code", 64'(q_full), 0);
        check(q_overflow == 1'b0, "R2", "overflow after unknown code", 64'(q_overflow), 0);
        expect_gnt(3'b000, 32'h0000_4100, 3'd1, 1'b0, "R2");
        send(4'b0000, 32'h0000_4100, 3'd1);
        check(q_full == 1'b1, "R2", "full after one read", 64'(q_full), 1);
        rd_force = 1'b1;
        idle(3);

        // R7: writes overtake a read waiting for data
        do_reset(8);
        expect_gnt(3'b010, 32'h0000_5040, 3'd0, 1'b0, "R7");
        expect_gnt(3'b010, 32'h0000_5080, 3'd0, 1'b0, "R7");
        expect_gnt(3'b000, 32'h0000_5000, 3'd4, 1'b0, "R6");
        send(4'b0000, 32'h0000_5000, 3'd4);
        send(4'b0100, 32'h0000_5040, 3'd0);
        send(4'b0100, 32'h0000_5080, 3'd0);
        idle(4);
        check(gnt_valid == 1'b0, "R6", "read granted without rd_ready", 64'(gnt_valid), 0);
        rd_force = 1'b1;
        idle(3);

        // R8: fence holds back a younger write
        do_reset(8);
        expect_gnt(3'b000, 32'h0000_6000, 3'd1, 1'b0, "R8");
        expect_gnt(3'b010, 32'h0000_6100, 3'd2, 1'b0, "R8");
        send(4'b0000, 32'h0000_6000, 3'd1);
        send(4'b1100, 32'h0000_0000, 3'd0);
        send(4'b0100, 32'h0000_6100, 3'd2);
        idle(4);
        check(gnt_valid == 1'b0, "R8", "write passed fence", 64'(gnt_valid), 0);
        rd_force = 1'b1;
        idle(5);

        // R9: flush completes without rd_ready, but waits behind an older read
        do_reset(8);
        expect_gnt(3'b000, 32'h0, 3'd0, 1'b1, "R9");
        send(4'b1010, 32'h0000_7777, 3'd5);
        idle(3);
        expect_gnt(3'b000, 32'h0000_7800, 3'd3, 1'b0, "R6");
        expect_gnt(3'b000, 32'h0, 3'd0, 1'b1, "R9");
        send(4'b0000, 32'h0000_7800, 3'd3);
        send(4'b1010, 32'h0000_7900, 3'd6);
        idle(4);
        check(gnt_valid == 1'b0, "R9", "flush passed older read", 64'(gnt_valid), 0);
        rd_force = 1'b1;
        idle(4);

        // R3 R4: depth limit, drop and sticky overflow
        do_reset(3);
        expect_gnt(3'b000, 32'h0000_8000, 3'd0, 1'b0, "R3");
        expect_gnt(3'b000, 32'h0000_8008, 3'd0, 1'b0, "R3");
        expect_gnt(3'b000, 32'h0000_8010, 3'd0, 1'b0, "R3");
        send(4'b0000, 32'h0000_8000, 3'd0);
        send(4'b0000, 32'h0000_8008, 3'd0);
        check(q_full == 1'b0, "R3", "full below limit", 64'(q_full), 0);
        send(4'b0000, 32'h0000_8010, 3'd0);
        check(q_full == 1'b1, "R3", "full at limit", 64'(q_full), 1);
        check(q_overflow == 1'b0, "R4", "overflow before drop", 64'(q_overflow), 0);
        send(4'b0000, 32'h0000_8018, 3'd0);
        check(q_overflow == 1'b1, "R4", "overflow after drop", 64'(q_overflow), 1);
        rd_force = 1'b1;
        idle(6);
        check(q_overflow == 1'b1, "R4", "overflow sticky", 64'(q_overflow), 1);
        do_reset(8);
        check(q_overflow == 1'b0, "R11", "overflow cleared by reset", 64'(q_overflow), 0);

        // R10: accept and issue in the same cycle while full -> drop
        do_reset(2);
        expect_gnt(3'b000, 32'h0000_9000, 3'd0, 1'b0, "R10");
        expect_gnt(3'b000, 32'h0000_9040, 3'd0, 1'b0, "R10");
        send(4'b0000, 32'h0000_9000, 3'd0);
        send(4'b0000, 32'h0000_9040, 3'd0);
        @(negedge clk);
        req_valid = 1'b1; req_cmd = 4'b0000; req_addr = 32'h0000_9080; req_len = 3'd0;
        rd_force = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rd_force = 1'b0;
        check(q_overflow == 1'b1, "R10", "drop while full despite issue", 64'(q_overflow), 1);
        idle(2);
        rd_force = 1'b1;
        idle(4);

        // R10: accept and issue in the same cycle below the limit
        do_reset(2);
        expect_gnt(3'b000, 32'h0000_A000, 3'd1, 1'b0, "R10");
        expect_gnt(3'b000, 32'h0000_A040, 3'd1, 1'b0, "R10");
        expect_gnt(3'b000, 32'h0000_A080, 3'd1, 1'b0, "R10");
        send(4'b0000, 32'h0000_A000, 3'd1);
        @(negedge clk);
        req_valid = 1'b1; req_cmd = 4'b0000; req_addr = 32'h0000_A040; req_len = 3'd1;
        rd_force = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rd_force = 1'b0;
        check(q_full == 1'b0, "R10", "full after swap", 64'(q_full), 0);
        send(4'b0000, 32'h0000_A080, 3'd1);
        check(q_full == 1'b1, "R10", "full after next accept", 64'(q_full), 1);
        rd_force = 1'b1;
        idle(4);

        // R6: stream through the fixed-latency responder keeps read order
        do_reset(8);
        mem_on = 1'b1;
        for (int k = 0; k < 4; k++) begin
            expect_gnt(3'b000, 32'h0000_B000 + 32'(k * 64), 3'(k), 1'b0, "R6");
        end
        expect_gnt(3'b000, 32'h0, 3'd0, 1'b1, "R6");
        expect_gnt(3'b000, 32'h0000_B800, 3'd6, 1'b0, "R6");
        for (int k = 0; k < 4; k++) begin
            send(4'b0000, 32'h0000_B000 + 32'(k * 64), 3'(k));
        end
        send(4'b1010, 32'h0000_B700, 3'd2);
        send(4'b0000, 32'h0000_B800, 3'd6);
        idle(30);
        mem_on = 1'b0;

        finish_run();
    end

endmodule